// File: doc/BRIEF.md
# Serial Bit Deframer with In-Band Escaping

This block sits behind a bit-recovery stage and turns a strobed stream of received bits into a byte stream for a receive FIFO. Every bit goes into an 8-bit history register. The block then looks at that register to find frame delimiters and abort sequences, and to spot the zeros a transmitter inserts after five consecutive ones. Each accepted bit is gathered into bytes, least significant bit first.

Frame boundaries are carried in the same byte stream as the data. Every delimiter seen produces a delimiter byte on the output. A data byte whose value equals the delimiter, abort or escape code is sent after an escape byte, so the consumer can tell data from framing. A level output reports whether the receiver is currently inside a frame.

Results pass through a small output queue with a valid/ready handshake toward the FIFO. The incoming bit stream cannot be held back. If the queue has no room for a whole result, the result is dropped.

Top module: `hdlc_deframer`

## Requirements
- R1: After reset, byte_valid_o and rx_active_o are low.
- R2: When the last eight received bits (newest in bit 0) equal FLAG_CODE (default 0x7E), the block queues one FLAG_CODE byte, sets rx_active_o and restarts byte assembly. This check is made before the abort check.
- R3: When the last eight received bits ANDed with ABORT_CODE (default 0x7F) equal ABORT_CODE, rx_active_o clears and nothing is queued.
- R4: While rx_active_o is low, bits that form neither a flag nor an abort produce no output.
- R5: Inside a frame, a 0 bit that follows five 1 bits (low six history bits equal to 111110) is discarded and not counted.
- R6: Accepted bits fill a byte starting at bit 0. After eight accepted bits, the byte is queued.
- R7: An assembled byte equal to 0x7E, 0x7F or 0x1B (the FLAG, ABORT and ESC_CODE values) is queued as ESC_CODE (0x1B) followed by the byte, on consecutive output transfers.
- R8: While byte_valid_o is high and out_ready_i is low, byte_o and byte_valid_o hold. Bytes leave in queue order, one per cycle with both high.
- R9: The output queue holds OUT_DEPTH bytes. A result (one byte, or an escape pair) that does not fit whole is dropped whole.
- R10: A cycle with bit_valid_i low changes neither the receive state nor rx_active_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_i | input | 1 | Received bit |
| bit_valid_i | input | 1 | Strobe: bit_i holds a new bit this cycle |
| out_ready_i | input | 1 | Receive FIFO can take a byte |
| byte_o | output | 8 | Head byte of the output queue |
| byte_valid_o | output | 1 | byte_o is valid |
| rx_active_o | output | 1 | High while inside a frame |

## Verification
The bench uses the default codes (0x7E, 0x7F, 0x1B) and an output depth of 4. With a depth of 4, holding ready low during a delimiter, one plain byte and one escaped byte fills the queue exactly, so the whole-result drop of the next byte can be observed. Sending bits only on every other cycle and toggling ready exercise the stall paths. Byte values chosen to force stuffing, and values equal to the three codes, exercise the stuffing removal and escape insertion paths.

// File: rtl/hdlc_deframer_pkg.sv
package hdlc_deframer_pkg;

    // One result from the bit stage: up to two bytes pushed together.
    typedef struct packed {
        logic       is_flag;
        logic       is_data;
        logic [1:0] n;
        logic [7:0] d0;
        logic [7:0] d1;
    } hdlc_emit_t;

    // Bit-stage register set.
    typedef struct packed {
        logic [7:0] hist;
        logic [7:0] acc;
        logic [2:0] cnt;
        logic       active;
    } hdlc_rx_state_t;

endpackage

// File: rtl/hdlc_bit_stage.sv
module hdlc_bit_stage
    import hdlc_deframer_pkg::*;
#(
    parameter logic [7:0] FLAG_CODE   = 8'h7E,
    parameter logic [7:0] ABORT_CODE  = 8'h7F,
    parameter logic [7:0] ESC_CODE    = 8'h1B,
    parameter int         STUFF_WIDTH = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_i,
    input  logic       valid_i,
    output hdlc_emit_t emit_o,
    output logic       active_o
);

    localparam logic [STUFF_WIDTH-1:0] STUFF_PAT = {{(STUFF_WIDTH-1){1'b1}}, 1'b0};
    localparam logic [2:0]             CNT_LAST  = 3'd7;

    hdlc_rx_state_t st_d, st_q;
    hdlc_emit_t     emit_d;
    logic [7:0]     hist_nx;
    logic [7:0]     acc_t;
    logic           needs_esc;

    always_comb begin
        st_d      = st_q;
        emit_d    = '0;
        hist_nx   = {st_q.hist[6:0], bit_i};
        acc_t     = {bit_i, st_q.acc[6:0]};
        needs_esc = (acc_t == FLAG_CODE) || (acc_t == ABORT_CODE) || (acc_t == ESC_CODE);

        if (valid_i) begin
            st_d.hist = hist_nx;
            if (hist_nx == FLAG_CODE) begin
                emit_d.is_flag = 1'b1;
                emit_d.n       = 2'd1;
                emit_d.d0      = FLAG_CODE;
                st_d.active    = 1'b1;
                st_d.acc       = '0;
                st_d.cnt       = '0;
            end else if ((hist_nx & ABORT_CODE) == ABORT_CODE) begin
                st_d.active = 1'b0;
            end else if (st_q.active && (hist_nx[STUFF_WIDTH-1:0] != STUFF_PAT)) begin
                if (st_q.cnt == CNT_LAST) begin
                    emit_d.is_data = 1'b1;
                    if (needs_esc) begin
                        emit_d.n  = 2'd2;
                        emit_d.d0 = ESC_CODE;
                        emit_d.d1 = acc_t;
                    end else begin
                        emit_d.n  = 2'd1;
                        emit_d.d0 = acc_t;
                    end
                    st_d.acc = '0;
                    st_d.cnt = '0;
                end else begin
                    st_d.acc = acc_t >> 1;
                    st_d.cnt = st_q.cnt + 3'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign emit_o   = emit_d;
    assign active_o = st_q.active;

endmodule

// File: rtl/hdlc_out_queue.sv
module hdlc_out_queue #(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [1:0]                   push_n,
    input  logic [7:0]                   push_d0,
    input  logic [7:0]                   push_d1,
    input  logic                         ready_i,
    output logic [7:0]                   data_o,
    output logic                         valid_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [IW-1:0]         rd;
        logic [IW-1:0]         wr;
        logic [CW-1:0]         cnt;
    } q_state_t;

    q_state_t q_d, q_q;
    logic          pop;
    logic          fits;
    logic [CW:0]   room;
    logic [CW:0]   cnt_nx;
    logic [IW-1:0] wr1;

    function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        q_d    = q_q;
        pop    = (q_q.cnt != '0) && ready_i;
        room   = (CW+1)'(DEPTH) - {1'b0, q_q.cnt} + (CW+1)'(pop);
        fits   = (push_n != 2'd0) && ((CW+1)'(push_n) <= room);
        wr1    = bump(q_q.wr);
        cnt_nx = {1'b0, q_q.cnt} - (CW+1)'(pop);

        if (pop) begin
            q_d.rd = bump(q_q.rd);
        end
        if (fits) begin
            q_d.mem[q_q.wr] = push_d0;
            if (push_n == 2'd2) begin
                q_d.mem[wr1] = push_d1;
                q_d.wr       = bump(wr1);
            end else begin
                q_d.wr = wr1;
            end
            cnt_nx = cnt_nx + (CW+1)'(push_n);
        end
        q_d.cnt = cnt_nx[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign data_o  = q_q.mem[q_q.rd];
    assign valid_o = (q_q.cnt != '0);
    assign count_o = q_q.cnt;

endmodule

// File: rtl/hdlc_deframer.sv
module hdlc_deframer
    import hdlc_deframer_pkg::*;
#(
    parameter logic [7:0] FLAG_CODE  = 8'h7E,
    parameter logic [7:0] ABORT_CODE = 8'h7F,
    parameter logic [7:0] ESC_CODE   = 8'h1B,
    parameter int         OUT_DEPTH  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_i,
    input  logic       bit_valid_i,
    input  logic       out_ready_i,
    output logic [7:0] byte_o,
    output logic       byte_valid_o,
    output logic       rx_active_o
);

    localparam int CW = $clog2(OUT_DEPTH + 1);

    hdlc_emit_t    bit_emit;
    logic [CW-1:0] q_count;

    hdlc_bit_stage #(
        .FLAG_CODE  (FLAG_CODE),
        .ABORT_CODE (ABORT_CODE),
        .ESC_CODE   (ESC_CODE),
        .STUFF_WIDTH(6)
    ) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_i   (bit_i),
        .valid_i (bit_valid_i),
        .emit_o  (bit_emit),
        .active_o(rx_active_o)
    );

    hdlc_out_queue #(
        .DEPTH(OUT_DEPTH)
    ) u_queue (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_n (bit_emit.n),
        .push_d0(bit_emit.d0),
        .push_d1(bit_emit.d1),
        .ready_i(out_ready_i),
        .data_o (byte_o),
        .valid_o(byte_valid_o),
        .count_o(q_count)
    );

endmodule

// File: rtl/hdlc_deframer_chk.sv
module hdlc_deframer_chk #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bit_valid_i,
    input logic                       out_ready_i,
    input logic [7:0]                 byte_o,
    input logic                       byte_valid_o,
    input logic                       rx_active_o,
    input logic                       flag_seen,
    input logic                       data_seen,
    input logic [$clog2(DEPTH+1)-1:0] occ
);

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o && !out_ready_i |=> byte_valid_o && $stable(byte_o)); // R8

    AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid_i |=> $stable(rx_active_o)); // R10

    AST_FLAG_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        flag_seen |=> rx_active_o); // R2

    AST_NO_DATA_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_active_o |-> !data_seen); // R4

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= ($clog2(DEPTH+1))'(DEPTH)); // R9

    AST_VALID_MATCHES_OCC: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o == (occ != '0)); // R8

endmodule

bind hdlc_deframer hdlc_deframer_chk #(.DEPTH(OUT_DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_valid_i (bit_valid_i),
    .out_ready_i (out_ready_i),
    .byte_o      (byte_o),
    .byte_valid_o(byte_valid_o),
    .rx_active_o (rx_active_o),
    .flag_seen   (bit_emit.is_flag),
    .data_seen   (bit_emit.is_data),
    .occ         (q_count)
);

// File: tb/hdlc_deframer_tb.sv
module hdlc_deframer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;
    localparam int FLAGV      = 8'h7E;
    localparam int ABORTV     = 8'h7F;
    localparam int ESCV       = 8'h1B;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_vld = 1'b0;
    logic       rdy = 1'b0;
    logic [7:0] byte_o;
    logic       bv;
    logic       act;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_deframer #(.OUT_DEPTH(DEPTH)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_i       (bit_in),
        .bit_valid_i (bit_vld),
        .out_ready_i (rdy),
        .byte_o      (byte_o),
        .byte_valid_o(bv),
        .rx_active_o (act)
    );

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    string cur_req = "R1";
    int    tx[$];
    int    mq[$];
    int    rx_log[$];
    int    exp_q[$];
    int    m_hist = 0, m_byte = 0, m_nb = 0, m_active = 0, tx_ones = 0;
    int    gap_mode = 0, ready_mode = 0;

    task automatic check(bit ok, string req, string what, int a, int e);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, a, e);
        end
    endtask

    task automatic model_push(int n, int d0, int d1);
        if (mq.size() + n <= DEPTH) begin
            mq.push_back(d0);
            if (n == 2) mq.push_back(d1);
        end
    endtask

    task automatic model_bit(int b);
        m_hist = ((m_hist << 1) | b) & 255;
        if (m_hist == FLAGV) begin
            m_active = 1; m_nb = 0; m_byte = 0;
            model_push(1, FLAGV, 0);
        end else if ((m_hist & ABORTV) == ABORTV) begin
            m_active = 0;
        end else if (m_active != 0 && (m_hist & 63) != 62) begin
            m_byte = m_byte | (b << m_nb);
            m_nb++;
            if (m_nb == 8) begin
                if (m_byte == FLAGV || m_byte == ABORTV || m_byte == ESCV)
                    model_push(2, ESCV, m_byte);
                else
                    model_push(1, m_byte, 0);
                m_nb = 0; m_byte = 0;
            end
        end
    endtask

    task automatic step();
        logic r;
        @(negedge clk);
        cyc++;
        check(bv === (mq.size() != 0), cur_req, "byte_valid_o", int'(bv), int'(mq.size() != 0));
        if (mq.size() != 0)
            check(byte_o === 8'(mq[0]), cur_req, "byte_o", int'(byte_o), mq[0]);
        check(act === (m_active != 0), cur_req, "rx_active_o", int'(act), m_active);
        r = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? (((cyc / 2) % 2) == 0) : 1'b0;
        if (bv && r) rx_log.push_back(int'(byte_o));
        if (mq.size() != 0 && r) void'(mq.pop_front());
        if (tx.size() != 0 && !(gap_mode != 0 && (cyc % 2) == 1)) begin
            int b;
            b = tx.pop_front();
            bit_vld = 1'b1;
            bit_in  = b[0];
            model_bit(b);
        end else begin
            bit_vld = 1'b0;
            bit_in  = ~bit_in;
        end
        rdy = r;
    endtask

    task automatic send_flag(bit track);
        for (int i = 0; i < 8; i++) tx.push_back((FLAGV >> i) & 1);
        tx_ones = 0;
        if (track) exp_q.push_back(FLAGV);
    endtask

    task automatic send_byte(int v, bit track);
        for (int i = 0; i < 8; i++) begin
            int bb;
            bb = (v >> i) & 1;
            tx.push_back(bb);
            if (bb == 1) begin
                tx_ones++;
                if (tx_ones == 5) begin
                    tx.push_back(0);
                    tx_ones = 0;
                end
            end else begin
                tx_ones = 0;
            end
        end
        if (track) begin
            if (v == FLAGV || v == ABORTV || v == ESCV) exp_q.push_back(ESCV);
            exp_q.push_back(v);
        end
    endtask

    task automatic send_ones(int n);
        for (int i = 0; i < n; i++) tx.push_back(1);
        tx_ones = 0;
    endtask

    task automatic wait_done();
        while (tx.size() != 0 || (ready_mode != 2 && mq.size() != 0)) step();
        repeat (4) step();
    endtask

    task automatic compare_log(string req);
        check(rx_log.size() == exp_q.size(), req, "byte count", rx_log.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < rx_log.size(); i++)
            check(rx_log[i] == exp_q[i], req, "byte value", rx_log[i], exp_q[i]);
        rx_log.delete();
        exp_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1";
        step();
        check(bv === 1'b0 && act === 1'b0, "R1", "valid/active after reset", int'({bv, act}), 0);

        // R4: bits before any flag are ignored
        cur_req = "R4";
        send_byte(8'h41, 0);
        send_byte(8'hC3, 0);
        wait_done();
        check(act === 1'b0, "R4", "inactive outside frame", int'(act), 0);
        compare_log("R4");

        // R2, R6: plain frame
        cur_req = "R6";
        send_flag(1); send_byte(8'h41, 1); send_byte(8'hA5, 1); send_byte(8'h00, 1);
        wait_done();
        check(act === 1'b1, "R2", "active after flag", int'(act), 1);
        send_flag(1);
        wait_done();
        compare_log("R6");

        // R5: values that force stuffed zeros
        cur_req = "R5";
        send_flag(1); send_byte(8'hFF, 1); send_byte(8'h3E, 1); send_byte(8'hFC, 1); send_byte(8'hF8, 1);
        send_flag(1);
        wait_done();
        compare_log("R5");

        // R7: colliding values get an escape prefix
        cur_req = "R7";
        send_flag(1); send_byte(8'h7E, 1); send_byte(8'h7F, 1); send_byte(8'h1B, 1); send_byte(8'h1C, 1);
        send_flag(1);
        wait_done();
        compare_log("R7");

        // R3: abort mid-frame, later bits ignored until the next flag
        cur_req = "R3";
        send_flag(1); send_byte(8'h12, 1);
        send_ones(9);
        send_byte(8'h55, 0);
        wait_done();
        check(act === 1'b0, "R3", "inactive after abort", int'(act), 0);
        send_flag(1); send_byte(8'h66, 1); send_flag(1);
        wait_done();
        compare_log("R3");

        // R8, R10: gapped bits and toggling ready
        cur_req = "R10";
        gap_mode = 1; ready_mode = 1;
        send_flag(1); send_byte(8'h5A, 1); send_byte(8'h7E, 1); send_byte(8'hE7, 1); send_flag(1);
        wait_done();
        ready_mode = 0;
        wait_done();
        compare_log("R8");
        gap_mode = 0;

        // R9: queue fills with ready low, next result dropped whole
        cur_req = "R9";
        ready_mode = 2;
        send_flag(1); send_byte(8'h41, 1); send_byte(8'h7E, 1); send_byte(8'h42, 0);
        wait_done();
        check(rx_log.size() == 0, "R8", "nothing leaves while ready low", rx_log.size(), 0);
        check(bv === 1'b1, "R9", "queue holds bytes", int'(bv), 1);
        ready_mode = 0;
        wait_done();
        compare_log("R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule